// File: doc/BRIEF.md
# Pixel Format Byte Packer

The packer sits between a pixel capture path and a 32-bit FIFO. Each accepted pixel carries 8-bit red, green and blue channels. A shared, programmable 8-bit alpha value applies to every pixel. A 2-bit format select picks one of four output layouts, and each layout gives the pixel a byte length of 4, 3 or 2. The packer appends those bytes to one continuous byte stream. It hands the stream downstream as little-endian 32-bit words, so the earliest byte of the stream occupies bits 7:0 of a word.

Pixels enter on a valid/ready handshake, and words leave on a second valid/ready handshake. When a pixel is flagged as the last of a frame, the packer sends any leftover bytes as a final, zero-padded word. A frame-start pulse throws away whatever partial data is held, so the next pixel begins again at byte 0 of a word. The format is sampled with each pixel, which means formats may be mixed inside a frame.

Top module: `pixel_packer`

## Requirements
- R1: After reset, `word_valid` is low and `pix_ready` is high.
- R2: With format 0, a pixel adds four bytes to the stream, in rising stream order alpha, blue, green, red.
- R3: With format 1, a pixel adds three bytes, in rising order blue, green, red. No padding is added, and a pixel may straddle two output words.
- R4: With format 2, a pixel adds a 16-bit value, low byte first, holding `alpha_val[7]` in bit 0, red[7:3] in bits 15:11, green[7:3] in bits 10:6 and blue[7:3] in bits 5:1.
- R5: With format 3, a pixel adds a 16-bit value, low byte first, holding green[7:2] in bits 10:5, blue[7:3] in bits 4:0 and red[7:3] in bits 15:11.
- R6: Output words carry the byte stream without gaps, with the earliest byte in bits 7:0. This holds when formats change from pixel to pixel.
- R7: While `word_valid` is high and `word_ready` is low, the word is held unchanged. `pix_ready` drops when no room would remain for a pixel.
- R8: After a pixel with `pix_last` is accepted, leftover bytes leave as one word with the unused upper bytes zero. `pix_ready` stays low until every byte has left.
- R9: A `frame_start` cycle discards all held bytes and any pending flush, and forces `word_valid` low. A pixel accepted in that same cycle is placed at byte 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse: discard partial data, restart alignment |
| fmt_sel | input | 2 | Output format: 0 ABGR8, 1 BGR8, 2 A1BGR5, 3 BGR565 |
| alpha_val | input | 8 | Alpha applied to every pixel |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Pixel accepted when high with pix_valid |
| pix_red | input | 8 | Red channel |
| pix_green | input | 8 | Green channel |
| pix_blue | input | 8 | Blue channel |
| pix_last | input | 1 | Pixel closes the frame; triggers flush |
| word_valid | output | 1 | Output word present |
| word_ready | input | 1 | Downstream takes the word |
| word_data | output | 32 | Packed little-endian word |

## Verification
Directed pixels with distinct byte values in every channel run in each format. They separate byte-order mistakes from bit-field mistakes in the 16-bit layouts, and an alpha with only its top bit set shows that the 1-bit alpha comes from bit 7. Runs of 3-byte pixels expose slips in word-boundary straddling and in flush padding. Random streams with mixed formats, random backpressure and frame restarts in mid-word are compared cycle by cycle against a byte-queue model, which detects lost, doubled or misaligned bytes and handshake violations.

// File: rtl/pxpack_pkg.sv
package pxpack_pkg;
  localparam int CH_W          = 8;
  localparam int WORD_BYTES    = 4;
  localparam int MAX_PIX_BYTES = 4;
  localparam int BUF_BYTES     = WORD_BYTES + MAX_PIX_BYTES - 1;
  localparam int CNT_W         = $clog2(BUF_BYTES + 1);
  localparam int WORD_W        = 8 * WORD_BYTES;
  localparam int PIX_W         = 8 * MAX_PIX_BYTES;
  localparam int BUF_W         = 8 * BUF_BYTES;

  typedef enum logic [1:0] {
    FMT_ABGR8  = 2'd0,
    FMT_BGR8   = 2'd1,
    FMT_A1BGR5 = 2'd2,
    FMT_BGR565 = 2'd3
  } fmt_e;

  // 16-bit layout with a single alpha bit in bit 0
  function automatic logic [15:0] pack_a1bgr5(logic [CH_W-1:0] r, logic [CH_W-1:0] g,
                                              logic [CH_W-1:0] b, logic [CH_W-1:0] a);
    return {r[CH_W-1 -: 5], g[CH_W-1 -: 5], b[CH_W-1 -: 5], a[CH_W-1]};
  endfunction

  // 16-bit layout with 6-bit green
  function automatic logic [15:0] pack_bgr565(logic [CH_W-1:0] r, logic [CH_W-1:0] g,
                                              logic [CH_W-1:0] b);
    return {r[CH_W-1 -: 5], g[CH_W-1 -: 6], b[CH_W-1 -: 5]};
  endfunction

  function automatic logic [CNT_W-1:0] fmt_len(fmt_e f);
    case (f)
      FMT_ABGR8: return CNT_W'(4);
      FMT_BGR8:  return CNT_W'(3);
      default:   return CNT_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/px_convert.sv
module px_convert
  import pxpack_pkg::*;
(
  input  fmt_e              fmt,
  input  logic [CH_W-1:0]   red,
  input  logic [CH_W-1:0]   green,
  input  logic [CH_W-1:0]   blue,
  input  logic [CH_W-1:0]   alpha,
  output logic [PIX_W-1:0]  bytes_out,
  output logic [CNT_W-1:0]  len_out
);
  // bytes_out[7:0] is the earliest byte; bytes past len_out stay zero
  always_comb begin
    bytes_out = '0;
    case (fmt)
      FMT_ABGR8:  bytes_out = {red, green, blue, alpha};
      FMT_BGR8:   bytes_out = PIX_W'({red, green, blue});
      FMT_A1BGR5: bytes_out = PIX_W'(pack_a1bgr5(red, green, blue, alpha));
      default:    bytes_out = PIX_W'(pack_bgr565(red, green, blue));
    endcase
    len_out = fmt_len(fmt);
  end
endmodule

// File: rtl/byte_accum.sv
module byte_accum
  import pxpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pop,
  input  logic              push,
  input  logic [PIX_W-1:0]  push_bytes,
  input  logic [CNT_W-1:0]  push_len,
  output logic [CNT_W-1:0]  fill,
  output logic [CNT_W-1:0]  fill_next,
  output logic [WORD_W-1:0] head_word
);
  logic [BUF_W-1:0] store_q, store_d, base_store;
  logic [CNT_W-1:0] fill_q, base_fill, pop_cnt;

  always_comb begin
    pop_cnt = '0;
    if (pop) pop_cnt = (fill_q >= CNT_W'(WORD_BYTES)) ? CNT_W'(WORD_BYTES) : fill_q;
    if (clr) begin
      base_store = '0;
      base_fill  = '0;
    end else begin
      base_store = pop ? (store_q >> WORD_W) : store_q;
      base_fill  = fill_q - pop_cnt;
    end
    store_d   = base_store;
    fill_next = base_fill;
    if (push) begin
      store_d   = base_store | (BUF_W'(push_bytes) << {base_fill, 3'b000});
      fill_next = base_fill + push_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      fill_q  <= '0;
    end else begin
      store_q <= store_d;
      fill_q  <= fill_next;
    end
  end

  assign fill      = fill_q;
  assign head_word = store_q[WORD_W-1:0];
endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
  import pxpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        fmt_sel,
  input  logic [CH_W-1:0]   alpha_val,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [CH_W-1:0]   pix_red,
  input  logic [CH_W-1:0]   pix_green,
  input  logic [CH_W-1:0]   pix_blue,
  input  logic              pix_last,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data
);
  logic [PIX_W-1:0]  cv_bytes;
  logic [CNT_W-1:0]  cv_len;
  logic [CNT_W-1:0]  acc_fill, acc_fill_next;
  logic              flush_q, flush_d;
  logic              word_fire, pix_fire, full_word;

  px_convert u_conv (
    .fmt       (fmt_e'(fmt_sel)),
    .red       (pix_red),
    .green     (pix_green),
    .blue      (pix_blue),
    .alpha     (alpha_val),
    .bytes_out (cv_bytes),
    .len_out   (cv_len)
  );

  assign full_word  = (acc_fill >= CNT_W'(WORD_BYTES));
  assign word_valid = !frame_start && (full_word || (flush_q && acc_fill != '0));
  assign pix_ready  = !flush_q && (!full_word || word_ready);
  assign word_fire  = word_valid && word_ready;
  assign pix_fire   = pix_valid && pix_ready;

  byte_accum u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (frame_start),
    .pop        (word_fire),
    .push       (pix_fire),
    .push_bytes (cv_bytes),
    .push_len   (cv_len),
    .fill       (acc_fill),
    .fill_next  (acc_fill_next),
    .head_word  (word_data)
  );

  always_comb begin
    flush_d = (frame_start ? 1'b0 : flush_q) || (pix_fire && pix_last);
    if (acc_fill_next == '0) flush_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end
endmodule

// File: rtl/pixel_packer_chk.sv
module pixel_packer_chk
  import pxpack_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              word_valid,
  input logic              word_ready,
  input logic [WORD_W-1:0] word_data,
  input logic              flush_q,
  input logic [CNT_W-1:0]  fill,
  input logic [CNT_W-1:0]  pix_len
);
  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(BUF_BYTES));

  // R6
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !frame_start && !(word_valid && word_ready))
    |=> fill == $past(fill) + $past(pix_len));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (frame_start || (word_valid && $stable(word_data))));

  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !pix_ready);

  // R8
  pad_only_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && fill < CNT_W'(WORD_BYTES)) |-> flush_q);

  // R9
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> fill <= CNT_W'(MAX_PIX_BYTES));
endmodule

bind pixel_packer pixel_packer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .pix_valid   (pix_valid),
  .pix_ready   (pix_ready),
  .word_valid  (word_valid),
  .word_ready  (word_ready),
  .word_data   (word_data),
  .flush_q     (flush_q),
  .fill        (acc_fill),
  .pix_len     (cv_len)
);

// File: tb/test_pixel_packer.sv
`timescale 1ns/1ps
module test_pixel_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [1:0]  fmt_sel;
  logic [7:0]  alpha_val;
  logic        pix_valid;
  logic        pix_ready;
  logic [7:0]  pix_red, pix_green, pix_blue;
  logic        pix_last;
  logic        word_valid;
  logic        word_ready;
  logic [31:0] word_data;

  always #2.5 clk = ~clk;

  pixel_packer i_pixel_packer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fmt_sel(fmt_sel),
    .alpha_val(alpha_val), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .pix_last(pix_last), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data)
  );

  int          n_tests = 0;
  int          n_fail  = 0;
  string       cur_req = "R1";
  logic [7:0]  mq[$];
  bit          mflush = 0;
  logic [31:0] got[$];
  bit          bp = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_push(logic [1:0] f, logic [7:0] r, logic [7:0] g, logic [7:0] b, logic [7:0] a);
    int v;
    case (f)
      2'd0: begin mq.push_back(a); mq.push_back(b); mq.push_back(g); mq.push_back(r); end
      2'd1: begin mq.push_back(b); mq.push_back(g); mq.push_back(r); end
      2'd2: begin
        v = (r / 8) * 2048 + (g / 8) * 64 + (b / 8) * 2 + (a / 128);
        mq.push_back(8'(v % 256)); mq.push_back(8'(v / 256));
      end
      default: begin
        v = (r / 8) * 2048 + (g / 4) * 32 + (b / 8);
        mq.push_back(8'(v % 256)); mq.push_back(8'(v / 256));
      end
    endcase
  endtask

  // one clock: drive ready, compare against model, advance model
  task automatic step(output bit acc);
    bit          ev, er;
    logic [31:0] ed;
    word_ready = bp ? ($urandom % 3 != 0) : 1'b1;
    #1;
    ev = !frame_start && (mq.size() >= 4 || (mflush && mq.size() > 0));
    ed = '0;
    for (int k = 0; k < 4; k++) if (k < mq.size()) ed[8*k +: 8] = mq[k];
    er = !mflush && (mq.size() < 4 || word_ready);
    chk(cur_req, "word_valid", 32'(word_valid), 32'(ev));
    if (ev) chk(cur_req, "word_data", word_data, ed);
    chk(cur_req, "pix_ready", 32'(pix_ready), 32'(er));
    acc = pix_valid && er;
    if (frame_start) begin
      mq.delete(); mflush = 0;
    end else if (ev && word_ready) begin
      got.push_back(word_data);
      for (int k = 0; k < 4; k++) if (mq.size() > 0) void'(mq.pop_front());
    end
    if (acc) begin
      model_push(fmt_sel, pix_red, pix_green, pix_blue, alpha_val);
      if (pix_last) mflush = 1;
    end
    if (mflush && mq.size() == 0) mflush = 0;
    @(negedge clk);
  endtask

  task automatic send(logic [1:0] f, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                      bit last, bit fs);
    bit acc;
    fmt_sel = f; pix_red = r; pix_green = g; pix_blue = b; pix_last = last;
    pix_valid = 1'b1; frame_start = fs;
    acc = 0;
    while (!acc) begin
      step(acc);
      frame_start = 1'b0;
    end
    pix_valid = 1'b0; pix_last = 1'b0;
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) step(acc);
  endtask

  task automatic drain();
    bit acc;
    for (int i = 0; i < 200 && (mq.size() > 0); i++) step(acc);
    idle(2);
  endtask

  initial begin
    #900us;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; frame_start = 0; fmt_sel = 0; alpha_val = 8'hFF; pix_valid = 0;
    pix_red = 0; pix_green = 0; pix_blue = 0; pix_last = 0; word_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "word_valid after reset", 32'(word_valid), 32'd0);
    chk("R1", "pix_ready after reset", 32'(pix_ready), 32'd1);
    @(negedge clk);

    // R2 ABGR8 directed
    cur_req = "R2"; got.delete(); alpha_val = 8'h11;
    send(2'd0, 8'h44, 8'h33, 8'h22, 1'b1, 1'b0);
    drain();
    chk("R2", "word count", 32'(got.size()), 32'd1);
    if (got.size() > 0) chk("R2", "ABGR8 word", got[0], 32'h44332211);

    // R3 BGR8 straddle and padding
    cur_req = "R3"; got.delete();
    send(2'd1, 8'h03, 8'h02, 8'h01, 1'b0, 1'b0);
    send(2'd1, 8'h06, 8'h05, 8'h04, 1'b1, 1'b0);
    drain();
    chk("R3", "word count", 32'(got.size()), 32'd2);
    if (got.size() > 1) begin
      chk("R3", "BGR8 word0", got[0], 32'h04030201);
      chk("R8", "padded word", got[1], 32'h00000605);
    end

    // R4 A1BGR5 using alpha bit 7 only
    cur_req = "R4"; got.delete(); alpha_val = 8'h80;
    send(2'd2, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0);
    alpha_val = 8'h7F;
    send(2'd2, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0);
    drain();
    if (got.size() > 0) chk("R4", "A1BGR5 word", got[0], 32'h07C0F83F);
    else chk("R4", "A1BGR5 word count", 32'd0, 32'd1);

    // R5 BGR565
    cur_req = "R5"; got.delete();
    send(2'd3, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0);
    send(2'd3, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0);
    drain();
    if (got.size() > 0) chk("R5", "BGR565 word", got[0], 32'h07E0F800);
    else chk("R5", "BGR565 word count", 32'd0, 32'd1);

    // R9 frame start drops partial bytes
    cur_req = "R9"; got.delete(); alpha_val = 8'hAA;
    send(2'd1, 8'h99, 8'h98, 8'h97, 1'b0, 1'b0);
    idle(2);
    send(2'd0, 8'hDD, 8'hCC, 8'hBB, 1'b0, 1'b1);
    drain();
    chk("R9", "word count", 32'(got.size()), 32'd1);
    if (got.size() > 0) chk("R9", "restart word", got[0], 32'hDDCCBBAA);

    // R8 flush under backpressure
    cur_req = "R8"; bp = 1;
    send(2'd1, 8'h10, 8'h20, 8'h30, 1'b1, 1'b0);
    drain();

    // R7 per-format random streams with backpressure
    cur_req = "R7";
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 40; i++) begin
        alpha_val = 8'($urandom);
        send(2'(f), 8'($urandom), 8'($urandom), 8'($urandom), i == 39, 1'b0);
        if ($urandom % 4 == 0) idle(1);
      end
      drain();
    end

    // R6 mixed formats with random restarts
    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      alpha_val = 8'($urandom);
      send(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           ($urandom % 25 == 0), ($urandom % 30 == 0));
      if ($urandom % 5 == 0) idle(1);
    end
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule